// File: doc/BRIEF.md
# Four-Character Memory-to-Serial Burst Sender

This block sends a short, fixed message over an asynchronous serial line. Four ASCII characters sit in the four lowest locations of a memory with a 16-bit read port. One press on the start input makes the block read those locations in turn and send each character as a serial frame. No further action is needed once the press has been accepted.

The start input comes from a mechanical button. The block synchronises it to the clock, filters out short glitches and reacts only to the rising edge of the filtered level. Each memory read returns its word one cycle after the read enable. The low byte of that word goes into a shift register and is sent as one start bit, eight data bits and one stop bit. A baud divider sets the bit period. A character counter stops the burst after the fourth location. The block then returns to idle and waits for the next press.

Top module: `byteBurstTx`

## Requirements
- R1: After reset `txOut` is 1, `busy` is 0 and `memRdEn` is 0.
- R2: `startIn` is synchronised and must stay at a new level for DEB_CYCLES consecutive clocks before it counts. A high pulse shorter than that starts nothing.
- R3: A rising edge of the filtered start level starts one burst. Holding `startIn` high does not start a second burst.
- R4: A burst reads addresses 0, 1, 2 and 3 in that order. Each read is a single-cycle `memRdEn` pulse, and `memAddr` never exceeds 3 while `memRdEn` is high.
- R5: The character sent for each read is bits [7:0] of `memRdData`, sampled one clock after the `memRdEn` pulse. Bits [15:8] are ignored.
- R6: Each character is framed as follows: a start bit of 0, then data bits from bit 0 up to bit 7, then a stop bit of 1. The line is 1 whenever the block is not busy.
- R7: Every bit lasts CLK_HZ/BAUD clock cycles.
- R8: `busy` rises when a request is accepted and stays high through the stop bit of the fourth character. It then falls and the line stays idle.
- R9: A start edge that arrives while `busy` is high is ignored. It adds no reads and no frames once the current burst ends.
- R10: After a burst ends, a new press is accepted. The new burst reads the memory again, so any changed contents are sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startIn | input | 1 | Raw start button level, asynchronous |
| memAddr | output | ADDR_W | Memory word address |
| memRdEn | output | 1 | Read strobe, one cycle per word |
| memRdData | input | DATA_W | Word returned one cycle after `memRdEn` |
| txOut | output | 1 | Serial transmit line, high when idle |
| busy | output | 1 | High from an accepted request to the end of the last stop bit |

## Verification
The burst is run with words whose upper halves hold junk, so that sending the wrong byte lane shows up. The character sets include 0xAA and 0x55, which tell bit-order and framing faults apart, and 0x00 and 0xFF, which test the start and stop bits against data bits of the same level. A glitch shorter than the filter window, a button held through a whole burst and a second press during a burst each check that only one clean edge starts a burst. A burst after the memory has been rewritten shows that the block re-reads its source rather than reusing held data. The length of a start bit followed by a 1 data bit measures the bit period directly.

// File: rtl/byteBurstTxPkg.sv
package byteBurstTxPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_LOAD,
    ST_SEND
  } seqState_t;

  typedef struct packed {
    logic readReq;
    logic loadByte;
  } ctrlStrobes_t;
endpackage

// File: rtl/startFilter.sv
module startFilter #(
  parameter int DEB_CYCLES = 500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic edgePulse
);
  localparam int DEB_W = $clog2(DEB_CYCLES + 1);

  logic [1:0]     syncReg;
  logic           debLevel;
  logic           debPrev;
  logic [DEB_W-1:0] stableCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncReg   <= '0;
      debLevel  <= 1'b0;
      debPrev   <= 1'b0;
      stableCnt <= '0;
    end else begin
      syncReg <= {syncReg[0], rawIn};
      debPrev <= debLevel;
      if (syncReg[1] == debLevel) begin
        stableCnt <= '0;
      end else if (stableCnt == DEB_W'(DEB_CYCLES - 1)) begin
        stableCnt <= '0;
        debLevel  <= syncReg[1];
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end
  end

  assign edgePulse = debLevel & ~debPrev;
endmodule

// File: rtl/burstControl.sv
module burstControl
  import byteBurstTxPkg::*;
#(
  parameter int NUM_CHARS = 4,
  parameter int ADDR_W    = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         startPulse,
  input  logic         frameDone,
  output ctrlStrobes_t strobes,
  output logic [ADDR_W-1:0] charAddr,
  output logic         busy
);
  localparam int IDX_W = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHARS - 1);

  seqState_t         state;
  logic [IDX_W-1:0]  charIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      charIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startPulse) begin
          charIdx <= '0;
          state   <= ST_READ;
        end
        ST_READ: state <= ST_LOAD;
        ST_LOAD: state <= ST_SEND;
        ST_SEND: if (frameDone) begin
          if (charIdx == LAST_IDX) begin
            state <= ST_IDLE;
          end else begin
            charIdx <= charIdx + 1'b1;
            state   <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.readReq  = (state == ST_READ);
    strobes.loadByte = (state == ST_LOAD);
  end

  assign charAddr = ADDR_W'(charIdx);
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/serialDatapath.sv
module serialDatapath
  import byteBurstTxPkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 9600
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strobes,
  input  logic [7:0]   charByte,
  output logic         txLine,
  output logic         frameDone
);
  localparam int BIT_CYCLES = CLK_HZ / BAUD;
  localparam int CNT_W      = $clog2(BIT_CYCLES + 1);
  localparam int FRAME_BITS = 10;

  logic [FRAME_BITS-1:0] shifter;
  logic                  active;
  logic [CNT_W-1:0]      baudCnt;
  logic [3:0]            bitIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      shifter   <= '1;
      active    <= 1'b0;
      baudCnt   <= '0;
      bitIdx    <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (strobes.loadByte) begin
        shifter <= {1'b1, charByte, 1'b0};
        active  <= 1'b1;
        baudCnt <= '0;
        bitIdx  <= '0;
      end else if (active) begin
        if (baudCnt == CNT_W'(BIT_CYCLES - 1)) begin
          baudCnt <= '0;
          shifter <= {1'b1, shifter[FRAME_BITS-1:1]};
          if (bitIdx == 4'(FRAME_BITS - 1)) begin
            active    <= 1'b0;
            frameDone <= 1'b1;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end else begin
          baudCnt <= baudCnt + 1'b1;
        end
      end
    end
  end

  assign txLine = active ? shifter[0] : 1'b1;
endmodule

// File: rtl/byteBurstTx.sv
module byteBurstTx
  import byteBurstTxPkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BAUD       = 9600,
  parameter int DEB_CYCLES = 500_000,
  parameter int NUM_CHARS  = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [DATA_W-1:0] memRdData,
  output logic              txOut,
  output logic              busy
);
  ctrlStrobes_t strobes;
  logic         startPulse;
  logic         frameDone;

  startFilter #(.DEB_CYCLES(DEB_CYCLES)) uFilter (
    .clk(clk), .rst(rst), .rawIn(startIn), .edgePulse(startPulse)
  );

  burstControl #(.NUM_CHARS(NUM_CHARS), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rst(rst), .startPulse(startPulse), .frameDone(frameDone),
    .strobes(strobes), .charAddr(memAddr), .busy(busy)
  );

  serialDatapath #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) uPath (
    .clk(clk), .rst(rst), .strobes(strobes), .charByte(memRdData[7:0]),
    .txLine(txOut), .frameDone(frameDone)
  );

  assign memRdEn = strobes.readReq;
endmodule

// File: rtl/byteBurstTxChecker.sv
module byteBurstTxChecker #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BAUD      = 9600,
  parameter int NUM_CHARS = 4,
  parameter int ADDR_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdEn,
  input logic              txLine,
  input logic              busy
);
  localparam int BIT_CYCLES = CLK_HZ / BAUD;

  int lowRun;
  always_ff @(posedge clk) begin
    if (rst || txLine) lowRun <= 0;
    else               lowRun <= lowRun + 1;
  end

  assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txLine);

  assert_addr_range_R4: assert property (@(posedge clk) disable iff (rst)
    memRdEn |-> (int'(memAddr) < NUM_CHARS));

  assert_single_read_R4: assert property (@(posedge clk) disable iff (rst)
    memRdEn |=> !memRdEn);

  assert_read_in_burst_R8: assert property (@(posedge clk) disable iff (rst)
    memRdEn |-> busy);

  assert_start_in_burst_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(txLine) |-> busy);

  assert_bit_period_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(txLine) |-> (lowRun != 0 && (lowRun % BIT_CYCLES) == 0));
endmodule

bind byteBurstTx byteBurstTxChecker #(
  .CLK_HZ(CLK_HZ), .BAUD(BAUD), .NUM_CHARS(NUM_CHARS), .ADDR_W(ADDR_W)
) chk (
  .clk(clk), .rst(rst), .memAddr(memAddr), .memRdEn(memRdEn),
  .txLine(txOut), .busy(busy)
);

// File: tb/byteBurstTx_test.sv
module byteBurstTx_test;
  localparam int CLK_HZ = 1_600_000;
  localparam int BAUD   = 100_000;
  localparam int BIT    = CLK_HZ / BAUD;
  localparam int DEB    = 8;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startIn = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic memRdEn;
  logic [15:0] memRdData = '0;
  logic txOut;
  logic busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] mem [16];
  int readCount = 0;
  int readLog [8];

  always #2.5 clk = ~clk;

  byteBurstTx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEB_CYCLES(DEB),
                .NUM_CHARS(4), .ADDR_W(ADDR_W), .DATA_W(16)) uut (
    .clk(clk), .rst(rst), .startIn(startIn), .memAddr(memAddr),
    .memRdEn(memRdEn), .memRdData(memRdData), .txOut(txOut), .busy(busy)
  );

  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= mem[memAddr];
      if (readCount < 8) readLog[readCount] <= int'(memAddr);
      readCount <= readCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitFall(output bit seen);
    seen = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (txOut == 1'b0) begin seen = 1; break; end
    end
  endtask

  // receive one frame; returns at the middle of the stop bit
  task automatic recvFrame(input logic [7:0] exp, input string tag);
    bit seen;
    logic [7:0] got;
    bit busyOk;
    waitFall(seen);
    check(seen, "R6", {tag, " start bit seen"}, seen, 1);
    busyOk = busy;
    repeat (BIT / 2 - 1) @(negedge clk);
    check(txOut == 1'b0, "R6", {tag, " start bit level"}, txOut, 0);
    for (int b = 0; b < 8; b++) begin
      repeat (BIT) @(negedge clk);
      got[b] = txOut;
      busyOk = busyOk & busy;
    end
    repeat (BIT) @(negedge clk);
    check(txOut == 1'b1, "R6", {tag, " stop bit level"}, txOut, 1);
    check(got == exp, "R5", {tag, " byte value (R6 LSB first)"}, got, exp);
    check(busyOk && busy, "R8", {tag, " busy during frame"}, busy, 1);
  endtask

  task automatic loadMem(input logic [15:0] w0, input logic [15:0] w1,
                         input logic [15:0] w2, input logic [15:0] w3);
    mem[0] = w0; mem[1] = w1; mem[2] = w2; mem[3] = w3;
  endtask

  task automatic pressFor(input int cycles);
    startIn = 1'b1;
    fork
      begin repeat (cycles) @(negedge clk); startIn = 1'b0; end
    join_none
  endtask

  task automatic quietWindow(input string req, input int startReads);
    bit quiet = 1;
    for (int i = 0; i < 3 * BIT; i++) begin
      @(negedge clk);
      if (txOut !== 1'b1 || busy !== 1'b0) quiet = 0;
    end
    check(quiet, req, "line idle and not busy after burst", quiet, 1);
    check(readCount == startReads, req, "no extra reads", readCount, startReads);
  endtask

  // one full burst; midPress adds a press during the burst (R9)
  task automatic runBurst(input string tag, input bit hold, input bit midPress);
    readCount = 0;
    pressFor(hold ? 2000 : 20);
    for (int c = 0; c < 4; c++) begin
      recvFrame(mem[c][7:0], $sformatf("%s char%0d", tag, c));
      if (midPress && c == 1) pressFor(20);
    end
    repeat (BIT / 2 + 6) @(negedge clk);
    check(busy == 1'b0, "R8", {tag, " busy low after last stop"}, busy, 0);
    check(readCount == 4, "R4", {tag, " four reads"}, readCount, 4);
    for (int c = 0; c < 4; c++)
      check(readLog[c] == c, "R4", {tag, " ascending address"}, readLog[c], c);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(txOut == 1'b1, "R1", "tx idle after reset", txOut, 1);
    check(busy == 1'b0, "R1", "busy low after reset", busy, 0);
    check(memRdEn == 1'b0, "R1", "no read after reset", memRdEn, 0);
  endtask

  task automatic testGlitch();
    bit none = 1;
    readCount = 0;
    startIn = 1'b1;
    repeat (DEB - 4) @(negedge clk);
    startIn = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (busy || !txOut) none = 0;
    end
    check(none, "R2", "short glitch starts nothing", none, 1);
    check(readCount == 0, "R2", "no read from glitch", readCount, 0);
  endtask

  task automatic testBitPeriod();
    bit seen;
    int lowLen = 0;
    loadMem(16'h3355, 16'h0041, 16'h0042, 16'h0043);
    readCount = 0;
    pressFor(20);
    waitFall(seen);
    while (txOut == 1'b0 && lowLen < 4 * BIT) begin
      lowLen++;
      @(negedge clk);
    end
    check(lowLen == BIT, "R7", "start bit length in cycles", lowLen, BIT);
    wait (busy == 1'b0);
    repeat (BIT) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) mem[i] = 16'hEE00 | 16'(i);

    testReset();
    testGlitch();

    loadMem(16'hA54A, 16'h5A4F, 16'hFF48, 16'h014E);
    runBurst("basic", 0, 0);

    loadMem(16'h12AA, 16'h3455, 16'h5600, 16'h78FF);
    runBurst("edge-bytes", 0, 0);

    runBurst("mid-press", 0, 1);
    quietWindow("R9", 4);

    loadMem(16'hC331, 16'hC332, 16'hC333, 16'hC334);
    runBurst("hold", 1, 0);
    quietWindow("R3", 4);
    wait (startIn == 1'b0);
    repeat (4 * DEB) @(negedge clk);

    loadMem(16'h0071, 16'h0072, 16'h0073, 16'h0074);
    runBurst("rewrite R10", 0, 0);

    testBitPeriod();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule